// File: doc/BRIEF.md
# Pulse Width Bounds Monitor

This block watches a single-bit condition and measures each run of consecutive clock cycles during which the condition is sampled true. A run that ends before it reaches a lower bound is reported as too short. A run that goes past an upper bound is reported as too long while it is still in progress, so the fault is visible without waiting for the run to end. Both bounds are elaboration-time parameters. The defaults accept runs of 4 to 10 cycles. Setting the parameters to 1 and 3 gives a tighter window.

Each error output is a one-cycle strobe. A sticky flag remembers that any violation has happened since reset. When a run ends, its measured length is placed on an output port and held there until the next run ends. The internal run counter stops at one past the upper bound, so a very long run never wraps the counter and never produces a misleading width. Holding the active-low reset low discards any run in progress and clears all outputs.

Top module: `pw_width_mon`

## Requirements
- R1: While rstN is low, and after it is released, shortErr, longErr and stickyErr read 0 and lastWidth reads 0 until the first run ends.
- R2: The run length N is the number of consecutive rising edges at which pulseIn is sampled 1. At the first edge that samples 0 after such a run, lastWidth takes the value N, or MAX_W+1 if N is larger than that.
- R3: If a run ends with N < MIN_W, shortErr is 1 for exactly the one cycle that follows the ending edge.
- R4: A run with MIN_W <= N <= MAX_W raises neither shortErr nor longErr.
- R5: At the edge where pulseIn is sampled 1 for the (MAX_W+1)-th consecutive time, longErr goes to 1 for one cycle, while the run is still in progress.
- R6: longErr fires at most once per run. It does not fire again until pulseIn has been sampled 0. A long run never raises shortErr.
- R7: The run counter saturates at MAX_W+1. A run of any length above MAX_W reports lastWidth = MAX_W+1.
- R8: stickyErr goes to 1 together with the first shortErr or longErr strobe and stays at 1 until reset.
- R9: lastWidth keeps its value while pulseIn stays low and during the following run. It changes only at the edge that ends a run.
- R10: Asserting reset in the middle of a run discards it. After release, counting starts from 1 at the first edge that samples pulseIn high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| pulseIn | input | 1 | Monitored condition |
| shortErr | output | 1 | One-cycle strobe: the run ended below MIN_W |
| longErr | output | 1 | One-cycle strobe: the run passed MAX_W |
| stickyErr | output | 1 | Set by any violation, cleared only by reset |
| lastWidth | output | $clog2(MAX_W+2) | Length of the most recent completed run, saturated at MAX_W+1 |

## Verification
The assertions assume that pulseIn is a clean synchronous signal that settles before each rising edge. They also assume that MIN_W is at least 1 and not above MAX_W, so that "below the minimum" and "beyond the maximum" can never both apply to one run. The stimulus changes pulseIn only on falling edges and uses run lengths from 1 up to well past MAX_W+1. This includes the exact boundary lengths MIN_W-1, MIN_W, MAX_W and MAX_W+1. The stimulus also releases reset while pulseIn is already high, to exercise the restart rule.

// File: rtl/pw_mon_pkg.sv
package pw_mon_pkg;

  // Strobes from the control to the datapath, valid for the current edge
  typedef struct packed {
    logic cntClr;    // the run has ended or never started
    logic cntInc;    // extend the run
    logic capture;   // latch the finished run length
    logic shortHit;  // the finished run was below the lower bound
    logic longHit;   // the run has just crossed the upper bound
  } pwStrobe_t;

  // Comparisons on the live counter, reported back to the control
  typedef struct packed {
    logic active;     // counter non-zero
    logic belowMin;   // counter below the lower bound
    logic atMax;      // counter equals the upper bound
    logic saturated;  // counter equals the upper bound plus one
  } pwStatus_t;

endpackage

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_mon_pkg::*;
(
  input  logic      pulseIn,
  input  pwStatus_t status,
  output pwStrobe_t strobe
);

  always_comb begin
    strobe          = '0;
    strobe.cntClr   = !pulseIn;
    strobe.cntInc   = pulseIn && !status.saturated;
    strobe.capture  = !pulseIn && status.active;
    strobe.shortHit = !pulseIn && status.active && status.belowMin;
    strobe.longHit  = pulseIn && status.atMax;
  end

endmodule

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_mon_pkg::*;
#(
  parameter int MIN_W = 4,
  parameter int MAX_W = 10,
  localparam int CNT_W = $clog2(MAX_W + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwStrobe_t        strobe,
  output pwStatus_t        status,
  output logic             shortErr,
  output logic             longErr,
  output logic             stickyErr,
  output logic [CNT_W-1:0] lastWidth
);

  localparam logic [CNT_W-1:0] MaxVal = CNT_W'(MAX_W);
  localparam logic [CNT_W-1:0] SatVal = CNT_W'(MAX_W + 1);

  logic [CNT_W-1:0] widthCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCnt <= '0;
    end else if (strobe.cntClr) begin
      widthCnt <= '0;
    end else if (strobe.cntInc) begin
      widthCnt <= widthCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastWidth <= '0;
      shortErr  <= 1'b0;
      longErr   <= 1'b0;
      stickyErr <= 1'b0;
    end else begin
      if (strobe.capture) lastWidth <= widthCnt;
      shortErr  <= strobe.shortHit;
      longErr   <= strobe.longHit;
      stickyErr <= stickyErr | strobe.shortHit | strobe.longHit;
    end
  end

  assign status.active    = (widthCnt != '0);
  assign status.atMax     = (widthCnt == MaxVal);
  assign status.saturated = (widthCnt == SatVal);

  // A lower bound of one cannot be violated by a run that exists
  generate
    if (MIN_W <= 1) begin : gNoMin
      assign status.belowMin = 1'b0;
    end else begin : gMin
      localparam logic [CNT_W-1:0] MinVal = CNT_W'(MIN_W);
      assign status.belowMin = (widthCnt < MinVal);
    end
  endgenerate

endmodule

// File: rtl/pw_width_mon.sv
module pw_width_mon
  import pw_mon_pkg::*;
#(
  parameter int MIN_W = 4,
  parameter int MAX_W = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         pulseIn,
  output logic                         shortErr,
  output logic                         longErr,
  output logic                         stickyErr,
  output logic [$clog2(MAX_W+2)-1:0]   lastWidth
);

  pwStrobe_t strobe;
  pwStatus_t status;

  pw_ctrl uCtrl (
    .pulseIn (pulseIn),
    .status  (status),
    .strobe  (strobe)
  );

  pw_datapath #(.MIN_W(MIN_W), .MAX_W(MAX_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .status    (status),
    .shortErr  (shortErr),
    .longErr   (longErr),
    .stickyErr (stickyErr),
    .lastWidth (lastWidth)
  );

endmodule

// File: rtl/pw_width_mon_chk.sv
module pw_width_mon_chk #(
  parameter int MIN_W = 4,
  parameter int MAX_W = 10
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       pulseIn,
  input logic                       shortErr,
  input logic                       longErr,
  input logic                       stickyErr,
  input logic [$clog2(MAX_W+2)-1:0] lastWidth
);

  AST_SHORT_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    shortErr |-> !$past(pulseIn)) else $error("short strobe without a falling run"); // R3

  AST_SHORT_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    shortErr |-> (int'(lastWidth) < MIN_W)) else $error("short strobe with in-range width"); // R3

  AST_LONG_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    longErr |-> $past(pulseIn)) else $error("long strobe outside a run"); // R5

  AST_LONG_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    longErr |=> !longErr) else $error("long strobe repeated"); // R6

  AST_NO_DUAL_ERR: assert property (@(posedge clk) disable iff (!rstN)
    !(shortErr && longErr)) else $error("both strobes at once"); // R6

  AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(lastWidth) <= MAX_W + 1) else $error("width beyond saturation"); // R7

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rstN)
    (shortErr || longErr) |-> stickyErr) else $error("sticky flag missed an error"); // R8

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stickyErr |=> stickyErr) else $error("sticky flag dropped"); // R8

  AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    pulseIn |=> $stable(lastWidth)) else $error("width changed mid-run"); // R9

endmodule

bind pw_width_mon pw_width_mon_chk #(.MIN_W(MIN_W), .MAX_W(MAX_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .pulseIn   (pulseIn),
  .shortErr  (shortErr),
  .longErr   (longErr),
  .stickyErr (stickyErr),
  .lastWidth (lastWidth)
);

// File: tb/tb_pw_width_mon.sv
`timescale 1ns/1ps
module tb_pw_width_mon;

  localparam int MIN_W = 4;
  localparam int MAX_W = 10;
  localparam int CNT_W = $clog2(MAX_W + 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pulseIn = 1'b0;
  logic shortErr, longErr, stickyErr;
  logic [CNT_W-1:0] lastWidth;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pw_width_mon #(.MIN_W(MIN_W), .MAX_W(MAX_W)) dut (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn),
    .shortErr(shortErr), .longErr(longErr),
    .stickyErr(stickyErr), .lastWidth(lastWidth)
  );

  typedef struct packed {
    int   runLen;
    logic expShort;
    logic expLong;
    int   expWidth;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1,  1'b1, 1'b0, 1},
    '{3,  1'b1, 1'b0, 3},
    '{4,  1'b0, 1'b0, 4},
    '{7,  1'b0, 1'b0, 7},
    '{10, 1'b0, 1'b0, 10},
    '{11, 1'b0, 1'b1, 11},
    '{15, 1'b0, 1'b1, 11},
    '{40, 1'b0, 1'b1, 11},
    '{2,  1'b1, 1'b0, 2}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge sample it, return at the next falling edge
  task automatic step(input logic v);
    pulseIn = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    logic expSticky;
    int held;
    @(negedge clk);
    doReset();
    // R1: state after reset
    chk("R1", "shortErr", shortErr, 0);
    chk("R1", "longErr", longErr, 0);
    chk("R1", "stickyErr", stickyErr, 0);
    chk("R1", "lastWidth", lastWidth, 0);

    // R4: an in-range run leaves everything clean
    for (int i = 0; i < 5; i++) step(1'b1);
    step(1'b0);
    chk("R4", "shortErr", shortErr, 0);
    chk("R4", "stickyErr", stickyErr, 0);
    chk("R2", "lastWidth", lastWidth, 5);

    expSticky = 1'b0;
    for (int v = 0; v < NV; v++) begin
      step(1'b0);
      step(1'b0);
      for (int i = 1; i <= VECS[v].runLen; i++) begin
        step(1'b1);
        // R5/R6: long strobe exactly once, at the overrun edge
        chk("R5", "longErr mid-run", longErr,
            (VECS[v].expLong && i == MAX_W + 1) ? 1 : 0);
        chk("R6", "shortErr mid-run", shortErr, 0);
      end
      step(1'b0);
      chk("R3", "shortErr at end", shortErr, VECS[v].expShort);
      chk("R7", "lastWidth at end", lastWidth, VECS[v].expWidth);
      chk("R6", "longErr at end", longErr, 0);
      expSticky = expSticky | VECS[v].expShort | VECS[v].expLong;
      step(1'b0);
      chk("R3", "shortErr one cycle", shortErr, 0);
      chk("R8", "stickyErr", stickyErr, expSticky);
    end

    // R9: width held through idle and through the next run
    held = lastWidth;
    for (int i = 0; i < 4; i++) step(1'b0);
    chk("R9", "lastWidth idle", lastWidth, held);
    for (int i = 0; i < 6; i++) begin
      step(1'b1);
      chk("R9", "lastWidth mid-run", lastWidth, held);
    end
    step(1'b0);
    chk("R2", "lastWidth six", lastWidth, 6);

    // R10 and R1: reset in mid-run, released with the input still high
    for (int i = 0; i < 8; i++) step(1'b1);
    rstN = 1'b0;
    #1;
    chk("R1", "stickyErr in reset", stickyErr, 0);
    chk("R1", "lastWidth in reset", lastWidth, 0);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1'b1);
      chk("R10", "longErr restarted", longErr, 0);
    end
    step(1'b0);
    chk("R10", "lastWidth restarted", lastWidth, 6);
    chk("R10", "shortErr restarted", shortErr, 0);
    chk("R8", "stickyErr after reset", stickyErr, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule